// File: doc/BRIEF.md
# Long-Packet Transmit Streamer

This block feeds a byte serializer from a small on-chip byte FIFO while allowing the packet to be far longer than the FIFO. Software programs a packet length and pulses a start strobe. It then pushes bytes through a single-cycle write port. A downstream consumer takes one byte per valid/ready handshake until the programmed number of bytes has left.

A running fill level is watched against a programmable low-water threshold. Each time draining pulls the level down across that threshold, a low-water pending bit is raised so software can top the FIFO up while transmission carries on. Completion is flagged once per packet. Writes that cannot be taken and a FIFO that empties before the packet ends are reported through two error pending bits. Each pending bit is gated by its own enable into a single interrupt line.

Top module: `pkt_tx_streamer`

## Requirements
- R1: After reset `out_valid_o`, `pend_o` and `irq_o` are all 0.
- R2: A `start_i` pulse with nonzero `pkt_len_i` latches the length and makes the block active. Bytes leave in write order, one per cycle with `out_valid_o` and `out_ready_i` both high. `out_valid_o` is high only while active, the FIFO is non-empty and `start_i` is low.
- R3: A packet longer than `DEPTH` bytes is sent in full and in order when software refills the FIFO during sending. While refill keeps the FIFO non-empty, no cycle with `out_ready_i` high sees `out_valid_o` low.
- R4: Pending bit 0 (low water) is set when a pop without a push takes the fill level from above `thresh_i` to at or below it. It fires once per crossing, and can fire several times in one packet.
- R5: Pending bit 1 (complete) is set exactly once, when the byte numbered `pkt_len_i` is accepted. After that the block is idle and presents no more bytes.
- R6: Pending bit 2 (overflow) is set by a write, outside a start cycle, that is dropped. A write is dropped when the block is idle, when the programmed length has already been written, or when the FIFO is full. Dropped bytes are never sent.
- R7: Pending bit 3 (underflow) is set when a pop empties the FIFO before the length is reached. `out_valid_o` then stays low until more bytes are written, and sending resumes with them.
- R8: `irq_o` is high exactly when some bit of `pend_o` and the same bit of `irq_en_i` are both 1.
- R9: Writing 1 to a bit of `irq_clr_i` clears that pending bit. A new event for the same bit in the same cycle wins and leaves it set.
- R10: `start_i` flushes the FIFO and the byte counters, and a write in the start cycle is ignored without setting overflow. A start with `pkt_len_i` = 0 leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a new packet, flush FIFO |
| pkt_len_i | input | LEN_W | Packet length in bytes, latched at start |
| thresh_i | input | CW | Low-water threshold on the fill level |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_data_i | input | DW | Host byte |
| irq_en_i | input | 4 | Per-bit interrupt enables |
| irq_clr_i | input | 4 | Write-1-to-clear for pending bits |
| pend_o | output | 4 | Pending bits: 0 low water, 1 complete, 2 overflow, 3 underflow |
| irq_o | output | 1 | Masked interrupt |
| out_valid_o | output | 1 | Byte available to the consumer |
| out_data_o | output | DW | Byte to the consumer |
| out_ready_i | input | 1 | Consumer takes the byte |

## Verification
The hardest case to reach is a second and third low-water crossing inside one packet. When the consumer takes a byte every cycle, refill writes only hold the level steady and never lift it back above the threshold. The stimulus therefore throttles the consumer to every other cycle while the host answers each low-water flag with a burst of forty writes, which raises the level well above the threshold before it drains again. A second hard case is a clear that lands in the same cycle as a fresh crossing. The stimulus sets that up by lowering the threshold by one after a first crossing and then popping a single byte with the clear asserted.

// File: rtl/pkt_tx_pkg.sv
package pkt_tx_pkg;
  localparam int unsigned NIRQ     = 4;
  localparam int unsigned IRQ_AE   = 0;
  localparam int unsigned IRQ_DONE = 1;
  localparam int unsigned IRQ_OVF  = 2;
  localparam int unsigned IRQ_UDF  = 3;
endpackage

// File: rtl/pkt_tx_fifo.sv
module pkt_tx_fifo #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          flush_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  output logic [DW-1:0] rdata_o,
  output logic [CW-1:0] count_o,
  output logic          empty_o,
  output logic          full_o
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_i) mem[wp_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) wp_q <= ptr_inc(wp_q);
      if (pop_i)  rp_q <= ptr_inc(rp_q);
      cnt_q <= cnt_q + CW'(push_i) - CW'(pop_i);
    end
  end

  assign rdata_o = mem[rp_q];
  assign count_o = cnt_q;
  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CW'(DEPTH));
endmodule

// File: rtl/pkt_tx_ctrl.sv
module pkt_tx_ctrl
  import pkt_tx_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CW    = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic [CW-1:0]    thresh_i,
  input  logic             wr_en_i,
  input  logic             out_ready_i,
  input  logic [CW-1:0]    count_i,
  input  logic             empty_i,
  input  logic             full_i,
  output logic             push_o,
  output logic             pop_o,
  output logic             flush_o,
  output logic             active_o,
  output logic             valid_o,
  output logic [LEN_W-1:0] wr_cnt_o,
  output logic [LEN_W-1:0] len_o,
  output logic [NIRQ-1:0]  ev_o
);
  logic             active_q;
  logic [LEN_W-1:0] len_q, wr_cnt_q, sent_q;
  logic [CW-1:0]    cnt_nxt;
  logic             last_byte;

  assign valid_o  = active_q && !empty_i && !start_i;
  assign pop_o    = valid_o && out_ready_i;
  assign push_o   = active_q && !start_i && wr_en_i && (wr_cnt_q < len_q) && !full_i;
  assign flush_o  = start_i;
  assign cnt_nxt  = count_i + CW'(push_o) - CW'(pop_o);
  assign last_byte = (sent_q == len_q - LEN_W'(1));

  always_comb begin
    ev_o           = '0;
    // falling crossing only: level above threshold before, at or below after
    ev_o[IRQ_AE]   = pop_o && (count_i > thresh_i) && (cnt_nxt <= thresh_i);
    ev_o[IRQ_DONE] = pop_o && last_byte;
    ev_o[IRQ_OVF]  = wr_en_i && !start_i && !push_o;
    ev_o[IRQ_UDF]  = pop_o && (cnt_nxt == '0) && !last_byte;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      len_q    <= '0;
      wr_cnt_q <= '0;
      sent_q   <= '0;
    end else if (start_i) begin
      active_q <= (pkt_len_i != '0);
      len_q    <= pkt_len_i;
      wr_cnt_q <= '0;
      sent_q   <= '0;
    end else begin
      if (push_o) wr_cnt_q <= wr_cnt_q + LEN_W'(1);
      if (pop_o)  sent_q   <= sent_q + LEN_W'(1);
      if (ev_o[IRQ_DONE]) active_q <= 1'b0;
    end
  end

  assign active_o = active_q;
  assign wr_cnt_o = wr_cnt_q;
  assign len_o    = len_q;
endmodule

// File: rtl/pkt_tx_irq.sv
module pkt_tx_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  input  logic [N-1:0] en_i,
  output logic [N-1:0] pend_o,
  output logic         irq_o
);
  logic [N-1:0] pend_q;

  for (genvar i = 0; i < N; i++) begin : g_pend
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      pend_q[i] <= 1'b0;
      else if (ev_i[i]) pend_q[i] <= 1'b1;
      else if (clr_i[i]) pend_q[i] <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = |(pend_q & en_i);
endmodule

// File: rtl/pkt_tx_streamer.sv
module pkt_tx_streamer
  import pkt_tx_pkg::*;
#(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LEN_W = 16,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [LEN_W-1:0] pkt_len_i,
  input  logic [CW-1:0]    thresh_i,
  input  logic             wr_en_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic [NIRQ-1:0]  irq_en_i,
  input  logic [NIRQ-1:0]  irq_clr_i,
  output logic [NIRQ-1:0]  pend_o,
  output logic             irq_o,
  output logic             out_valid_o,
  output logic [DW-1:0]    out_data_o,
  input  logic             out_ready_i
);
  logic             push, pop, flush, active, empty, full;
  logic [CW-1:0]    cnt;
  logic [LEN_W-1:0] wr_cnt, len_q;
  logic [NIRQ-1:0]  ev;

  pkt_tx_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .flush_i (flush),
    .push_i  (push),
    .wdata_i (wr_data_i),
    .pop_i   (pop),
    .rdata_o (out_data_o),
    .count_o (cnt),
    .empty_o (empty),
    .full_o  (full)
  );

  pkt_tx_ctrl #(.LEN_W(LEN_W), .CW(CW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (start_i),
    .pkt_len_i   (pkt_len_i),
    .thresh_i    (thresh_i),
    .wr_en_i     (wr_en_i),
    .out_ready_i (out_ready_i),
    .count_i     (cnt),
    .empty_i     (empty),
    .full_i      (full),
    .push_o      (push),
    .pop_o       (pop),
    .flush_o     (flush),
    .active_o    (active),
    .valid_o     (out_valid_o),
    .wr_cnt_o    (wr_cnt),
    .len_o       (len_q),
    .ev_o        (ev)
  );

  pkt_tx_irq #(.N(NIRQ)) u_irq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ev_i   (ev),
    .clr_i  (irq_clr_i),
    .en_i   (irq_en_i),
    .pend_o (pend_o),
    .irq_o  (irq_o)
  );
endmodule

// File: rtl/pkt_tx_streamer_chk.sv
module pkt_tx_streamer_chk
  import pkt_tx_pkg::*;
#(
  parameter int unsigned DEPTH = 64,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CW    = 7
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             active,
  input logic [NIRQ-1:0]  ev,
  input logic [CW-1:0]    cnt,
  input logic [CW-1:0]    thresh_i,
  input logic [LEN_W-1:0] wr_cnt,
  input logic [LEN_W-1:0] len_q,
  input logic             out_valid_o,
  input logic [NIRQ-1:0]  pend_o,
  input logic [NIRQ-1:0]  irq_en_i,
  input logic             irq_o
);
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !out_valid_o); // R2
  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt <= CW'(DEPTH)); // R3
  AST_AE_ONCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev[IRQ_AE] ##1 $stable(thresh_i)) |-> !ev[IRQ_AE]); // R4
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev[IRQ_DONE] |=> !active); // R5
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active |-> wr_cnt <= len_q); // R6
  AST_UDF_STALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev[IRQ_UDF] |=> !out_valid_o); // R7
  AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pend_o & irq_en_i) == '0) |-> !irq_o); // R8
  AST_EVT_WINS_AE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev[IRQ_AE] |=> pend_o[IRQ_AE]); // R9
  AST_EVT_WINS_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev[IRQ_DONE] |=> pend_o[IRQ_DONE]); // R9
endmodule

bind pkt_tx_streamer pkt_tx_streamer_chk #(.DEPTH(DEPTH), .LEN_W(LEN_W), .CW(CW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .active      (active),
  .ev          (ev),
  .cnt         (cnt),
  .thresh_i    (thresh_i),
  .wr_cnt      (wr_cnt),
  .len_q       (len_q),
  .out_valid_o (out_valid_o),
  .pend_o      (pend_o),
  .irq_en_i    (irq_en_i),
  .irq_o       (irq_o)
);

// File: tb/pkt_tx_streamer_tb.sv
module pkt_tx_streamer_tb;
  localparam int DW = 8, DEPTH = 64, LEN_W = 16, CW = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 0, wr_en = 0, out_ready = 0;
  logic [LEN_W-1:0] pkt_len = '0;
  logic [CW-1:0] thresh = '0;
  logic [DW-1:0] wr_data = '0;
  logic [3:0] irq_en = '0, irq_clr = '0;
  logic [3:0] pend;
  logic irq, out_valid;
  logic [DW-1:0] out_data;

  always #5 clk = ~clk;

  pkt_tx_streamer #(.DW(DW), .DEPTH(DEPTH), .LEN_W(LEN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .pkt_len_i(pkt_len),
    .thresh_i(thresh), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .irq_en_i(irq_en), .irq_clr_i(irq_clr), .pend_o(pend), .irq_o(irq),
    .out_valid_o(out_valid), .out_data_o(out_data), .out_ready_i(out_ready)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural reference
  logic [7:0] q[$];
  bit m_active;
  int m_len, m_wr, m_sent;
  logic [3:0] m_pend;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete(); m_active = 0; m_len = 0; m_wr = 0; m_sent = 0; m_pend = '0;
    end else begin
      int sz, nsz;
      bit pp, ps;
      logic [3:0] ev;
      sz = q.size();
      pp = m_active && !start && sz > 0 && out_ready;
      ps = m_active && !start && wr_en && m_wr < m_len && sz < DEPTH;
      nsz = sz - int'(pp) + int'(ps);
      ev = '0;
      ev[0] = pp && sz > int'(thresh) && nsz <= int'(thresh);
      ev[1] = pp && m_sent == m_len - 1;
      ev[2] = wr_en && !start && !ps;
      ev[3] = pp && nsz == 0 && m_sent + 1 < m_len;
      m_pend = (m_pend & ~irq_clr) | ev;
      if (start) begin
        q.delete(); m_active = (pkt_len != 0); m_len = int'(pkt_len); m_wr = 0; m_sent = 0;
      end else begin
        if (pp) begin void'(q.pop_front()); m_sent++; end
        if (ps) begin q.push_back(wr_data); m_wr++; end
        if (ev[1]) m_active = 0;
      end
    end
  end

  int hs = 0, gaps = 0;
  bit track_gap = 0;

  // compare mid-cycle, then advance one edge
  task automatic cyc();
    bit ev_;
    #4;
    ev_ = m_active && q.size() > 0 && !start;
    chk(out_valid == ev_, "R2", "out_valid", int'(out_valid), int'(ev_));
    if (ev_) chk(out_data == q[0], "R3", "out_data", int'(out_data), int'(q[0]));
    chk(pend[0] == m_pend[0], "R4", "pend_lowwater", int'(pend[0]), int'(m_pend[0]));
    chk(pend[1] == m_pend[1], "R5", "pend_done", int'(pend[1]), int'(m_pend[1]));
    chk(pend[2] == m_pend[2], "R6", "pend_ovf", int'(pend[2]), int'(m_pend[2]));
    chk(pend[3] == m_pend[3], "R7", "pend_udf", int'(pend[3]), int'(m_pend[3]));
    chk(irq == |(m_pend & irq_en), "R8", "irq", int'(irq), int'(|(m_pend & irq_en)));
    if (out_valid && out_ready) hs++;
    if (track_gap && m_active && out_ready && !out_valid) gaps++;
    @(posedge clk); #1;
  endtask

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  task automatic wr_bytes(input int n, input int base);
    for (int i = 0; i < n; i++) begin
      wr_en = 1; wr_data = pat(base + i); cyc();
    end
    wr_en = 0;
  endtask

  task automatic go(input int len);
    pkt_len = LEN_W'(len); start = 1; cyc(); start = 0;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int ae_seen, budget, widx, done_rise;
    bit last_done;
    // R1 reset state
    #23;
    chk(out_valid == 0, "R1", "reset out_valid", int'(out_valid), 0);
    chk(pend == 0, "R1", "reset pend", int'(pend), 0);
    chk(irq == 0, "R1", "reset irq", int'(irq), 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R3/R4/R5: 150-byte packet through a 64-byte FIFO
    thresh = 16; irq_en = 4'b0011;
    go(150);
    wr_bytes(DEPTH, 0);
    widx = DEPTH; budget = 0; ae_seen = 0; hs = 0; gaps = 0; done_rise = 0; last_done = 0;
    track_gap = 1;
    for (int c = 0; c < 3000; c++) begin
      irq_clr = '0; wr_en = 0;
      if (pend[1]) break;
      if (pend[0]) begin irq_clr = 4'b0001; budget += 40; ae_seen++; end
      if (budget > 0 && widx < 150) begin
        wr_en = 1; wr_data = pat(widx); widx++; budget--;
      end
      out_ready = c[0];
      cyc();
      if (pend[1] && !last_done) done_rise++;
      last_done = pend[1];
    end
    track_gap = 0; wr_en = 0; irq_clr = '0;
    chk(ae_seen >= 2, "R4", "low-water events in one packet", ae_seen, 2);
    chk(gaps == 0, "R3", "ready cycles without a byte", gaps, 0);
    chk(hs == 150, "R3", "bytes sent", hs, 150);
    chk(done_rise == 1, "R5", "completion flags", done_rise, 1);
    out_ready = 1; irq_clr = 4'b0010; cyc(); irq_clr = '0;
    repeat (4) cyc();
    chk(pend[1] == 0 && out_valid == 0, "R5", "no second completion", int'({pend[1], out_valid}), 0);

    // R6 overflow beyond length
    irq_clr = 4'hF; cyc(); irq_clr = '0; out_ready = 0;
    go(5);
    wr_bytes(7, 200);
    chk(pend[2] == 1, "R6", "overflow flag", int'(pend[2]), 1);
    hs = 0; out_ready = 1;
    repeat (8) cyc();
    chk(hs == 5, "R6", "bytes sent with extra writes", hs, 5);
    chk(pend[1] == 1, "R6", "complete after 5", int'(pend[1]), 1);

    // R7 underflow and resume
    irq_clr = 4'hF; out_ready = 0; cyc(); irq_clr = '0;
    go(10);
    wr_bytes(3, 300);
    hs = 0; out_ready = 1;
    repeat (5) cyc();
    chk(pend[3] == 1, "R7", "underflow flag", int'(pend[3]), 1);
    chk(out_valid == 0, "R7", "stalled output", int'(out_valid), 0);
    wr_bytes(7, 303);
    repeat (5) cyc();
    chk(hs == 10, "R7", "bytes after resume", hs, 10);
    chk(pend[1] == 1, "R7", "complete after resume", int'(pend[1]), 1);

    // R8 enable masking
    irq_en = 4'b0000; cyc();
    chk(irq == 0, "R8", "irq all masked", int'(irq), 0);
    irq_en = 4'b1000; cyc();
    chk(irq == 1, "R8", "irq underflow enabled", int'(irq), 1);
    irq_en = 4'b0100; cyc();
    chk(irq == 0, "R8", "irq overflow enabled, none pending", int'(irq), 0);

    // R9 clear versus same-cycle event
    irq_clr = 4'hF; out_ready = 0; cyc(); irq_clr = '0;
    go(8);
    wr_bytes(4, 400);
    thresh = 3; out_ready = 1; cyc();
    out_ready = 0; thresh = 2; cyc();
    chk(pend[0] == 1, "R9", "low water after first crossing", int'(pend[0]), 1);
    out_ready = 1; irq_clr = 4'b0001; cyc();
    chk(pend[0] == 1, "R9", "event beats clear", int'(pend[0]), 1);
    out_ready = 0; cyc();
    chk(pend[0] == 0, "R9", "plain clear", int'(pend[0]), 0);
    irq_clr = '0;

    // R10 zero length and flush on start
    irq_clr = 4'hF; pkt_len = '0; start = 1; cyc(); start = 0; irq_clr = '0;
    out_ready = 1;
    wr_bytes(2, 500);
    chk(pend[2] == 1, "R10", "writes while idle overflow", int'(pend[2]), 1);
    chk(out_valid == 0, "R10", "zero length sends nothing", int'(out_valid), 0);
    irq_clr = 4'hF; cyc(); irq_clr = '0;
    pkt_len = 16'd3; start = 1; wr_en = 1; wr_data = 8'hEE; cyc(); start = 0; wr_en = 0;
    chk(pend[2] == 0, "R10", "start-cycle write no overflow", int'(pend[2]), 0);
    chk(out_valid == 0, "R10", "FIFO flushed by start", int'(out_valid), 0);
    hs = 0;
    wr_bytes(3, 600);
    repeat (3) cyc();
    chk(hs == 3, "R10", "bytes after restart", hs, 3);
    chk(pend[1] == 1, "R10", "complete after restart", int'(pend[1]), 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule